// File: doc/BRIEF.md
# MDIO Management Master

This block gives a host a small register window for reaching the management registers of Ethernet PHYs over a two-wire serial management bus. The bus is a clock that only the master drives and a bidirectional data line. The host sets a clock divider and an enable bit in a control register. It then writes one command word that holds the PHY address, the register number, the direction and, for writes, the data. A GO flag in that word starts the transaction and clears by itself when the serial frame has finished. For reads, the same word then holds the returned data and an acknowledge flag.

When the host has no command waiting and the block is enabled, the engine reads register 1 of each PHY address in turn. It records in a 32-bit presence map whether each address answered. Host reads also update that map. A host command waits only for the background frame already in progress and then takes the bus.

Register window (reg_addr): 0 = control, 1 = command, 2 = presence map, 3 = reads zero.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, control reads 32'h8000_0000 (idle set, enable clear, divider 0), command and presence map read 0, mdc is low and mdio_oe is low.
- R2: Control layout: bits [7:0] are the divider, bit 30 is enable and bit 31 (read-only) is idle. Command layout: bit 31 GO, bit 30 write (1 = write frame, 0 = read frame), bit 29 ACK (read-only), bits [25:21] register, bits [20:16] PHY address, bits [15:0] data. A command write with GO clear stores the fields and starts nothing.
- R3: Writing the command word with GO set starts a transaction. GO reads 1 until the frame ends and then clears by itself.
- R4: A read frame is 32 ones, then 01, opcode 10, PHY address, register (both MSB first), then turnaround and 16 data bits. The master drives the line for the first 46 bits and releases it from the first turnaround bit to the end.
- R5: A write frame uses opcode 01, turnaround 10 and the 16 data bits MSB first. The master drives the line for all 64 bits. The data line changes only when mdc falls.
- R6: After a read, ACK is 1 only if the second turnaround bit sampled low. Bits [15:0] hold the 16 sampled data bits, which read 16'hFFFF from an absent PHY on a pulled-up line. After a write, ACK reads 0.
- R7: One mdc period lasts (divider + 1) clock cycles. A divider of 0 acts as 1. The master samples the data line on the rising mdc edge.
- R8: A command write while GO is set changes nothing. The running or pending transaction keeps its fields.
- R9: Presence bit n equals the ACK of the latest completed read to PHY address n, whether from the host or from the background scan. The map changes only when a frame completes.
- R10: While enabled with no host command pending, the block reads register 1 of PHY addresses in ascending order, wrapping from 31 to 0.
- R11: While enable is clear, no frame starts. A GO written meanwhile stays pending and mdc stays low.
- R12: The idle bit reads 0 exactly while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line value seen at the pin |

## Verification
The assertions assume that the data line is pulled high when nobody drives it, and that a PHY changes the line only after a falling mdc edge, so that every rising-edge sample sees a settled value. The bench PHY model follows this. It drives only in the turnaround and data slots of reads addressed to a present PHY, and it changes its output only on falling mdc edges. Host writes, including divider changes made while background frames run, are applied away from the clock edge. The assertions tolerate these divider changes because the bit-stability check counts from each bit boundary.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_CMD   = 2'd1;
  localparam logic [1:0] A_ALIVE = 2'd2;
  localparam int         FLEN    = 64;
  localparam logic [5:0] LAST    = 6'(FLEN - 1);
  localparam logic [5:0] TA1     = 6'd46;
  localparam logic [5:0] TA2     = 6'd47;
  localparam logic [5:0] DAT0    = 6'd48;

  logic [DIV_W-1:0] div_q;
  logic             en_q;
  logic             go_q, wr_q, ack_q;
  logic [4:0]       ra_q, pa_q;
  logic [15:0]      dat_q;
  logic [31:0]      alive_q;

  logic             busy, f_host, f_rd, ack_r;
  logic [DIV_W-1:0] cnt;
  logic [5:0]       bitn;
  logic [63:0]      sh;
  logic [15:0]      rx;
  logic [4:0]       f_pa, poll_pa;

  wire [DIV_W-1:0] dcap   = (div_q == '0) ? DIV_W'(1) : div_q;
  wire [DIV_W-1:0] half   = DIV_W'(({1'b0, dcap} + (DIV_W+1)'(1)) >> 1);
  wire [DIV_W-1:0] cnt_nx = cnt + DIV_W'(1);
  wire             start  = !busy && en_q;
  wire             n_rd   = go_q ? !wr_q : 1'b1;
  wire [4:0]       n_pa   = go_q ? pa_q : poll_pa;
  wire [4:0]       n_ra   = go_q ? ra_q : 5'd1;
  wire [63:0]      frame  = {32'hFFFF_FFFF, 2'b01, n_rd ? 2'b10 : 2'b01, n_pa, n_ra,
                             2'b10, n_rd ? 16'hFFFF : dat_q};
  wire             bit_end = busy && (cnt >= dcap);
  wire             done    = bit_end && (bitn == LAST);
  wire             cmd_wr  = reg_wr && (reg_addr == A_CMD) && !go_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      en_q  <= 1'b0;
    end else if (reg_wr && reg_addr == A_CTRL) begin
      div_q <= reg_wdata[DIV_W-1:0];
      en_q  <= reg_wdata[30];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q <= 1'b0; wr_q <= 1'b0; ack_q <= 1'b0;
      ra_q <= '0;   pa_q <= '0;   dat_q <= '0;
    end else if (cmd_wr) begin
      go_q  <= reg_wdata[31];
      wr_q  <= reg_wdata[30];
      ack_q <= 1'b0;
      ra_q  <= reg_wdata[25:21];
      pa_q  <= reg_wdata[20:16];
      dat_q <= reg_wdata[15:0];
    end else if (done && f_host) begin
      go_q <= 1'b0;
      if (f_rd) begin
        ack_q <= ack_r;
        dat_q <= rx;
      end else begin
        ack_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      alive_q <= '0;
    else if (done && f_rd)
      alive_q[f_pa] <= ack_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; f_host <= 1'b0; f_rd <= 1'b0; ack_r <= 1'b0;
      cnt <= '0; bitn <= '0; sh <= '0; rx <= '0;
      f_pa <= '0; poll_pa <= '0;
      mdc <= 1'b0; mdio_o <= 1'b1; mdio_oe <= 1'b0;
    end else if (!busy) begin
      mdc     <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        f_host  <= go_q;
        f_rd    <= n_rd;
        f_pa    <= n_pa;
        cnt     <= '0;
        bitn    <= '0;
        sh      <= {frame[62:0], 1'b0};
        mdio_o  <= frame[63];
        mdio_oe <= 1'b1;
        ack_r   <= 1'b0;
        rx      <= '0;
        if (!go_q) poll_pa <= poll_pa + 5'd1;
      end
    end else if (bit_end) begin
      mdc <= 1'b0;
      cnt <= '0;
      if (bitn == LAST) begin
        busy    <= 1'b0;
        mdio_oe <= 1'b0;
        mdio_o  <= 1'b1;
      end else begin
        bitn    <= bitn + 6'd1;
        mdio_o  <= sh[63];
        sh      <= {sh[62:0], 1'b0};
        mdio_oe <= !(f_rd && (bitn >= TA1 - 6'd1));
      end
    end else begin
      cnt <= cnt_nx;
      if (cnt_nx == half) begin
        mdc <= 1'b1;
        if (f_rd && bitn == TA2) ack_r <= !mdio_i;
        if (f_rd && bitn >= DAT0) rx <= {rx[14:0], mdio_i};
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {!busy, en_q, (30-DIV_W)'(0), div_q};
      A_CMD:   reg_rdata = {go_q, wr_q, ack_q, 3'b000, ra_q, pa_q, dat_q};
      A_ALIVE: reg_rdata = alive_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_GO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !done) |=> go_q); // R3

  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && reg_wr && reg_addr == A_CMD && !done) |=>
      ($stable(pa_q) && $stable(ra_q) && $stable(dat_q) && $stable(wr_q))); // R8

  AST_TA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && f_rd && bitn >= TA1) |-> !mdio_oe); // R4

  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !f_rd) |-> mdio_oe); // R5

  AST_BIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && cnt != '0) |-> $stable(mdio_o)); // R5

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !en_q) |=> (!busy && !mdc)); // R11

  AST_ALIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(alive_q)); // R9

endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic phy_drv = 1'b0, phy_val = 1'b1;
  wire  mdio_bus = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

  always #5 clk = ~clk;

  mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_bus));

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [31:0] phy_present = 32'h8000_0113;
  logic [15:0] phy_mem [0:1023];
  logic [15:0] exp_mem [0:1023];

  // PHY model
  logic [33:0] psh = '0;
  bit pin = 1'b0;
  int pk = 0;
  logic [1:0] pop;
  logic [4:0] ppa, pra;
  logic [15:0] pwd;
  bit presp = 1'b0;

  always @(posedge mdc) begin
    if (!pin) begin
      psh = {psh[32:0], mdio_bus};
      if (psh == {32'hFFFF_FFFF, 2'b01}) begin pin = 1'b1; pk = 0; end
    end else begin
      if (pk < 2) pop = {pop[0], mdio_bus};
      else if (pk < 7) ppa = {ppa[3:0], mdio_bus};
      else if (pk < 12) pra = {pra[3:0], mdio_bus};
      else if (pk >= 14) pwd = {pwd[14:0], mdio_bus};
      if (pk == 11) presp = phy_present[ppa];
      if (pk == 29) begin
        pin = 1'b0; psh = '0;
        if (pop == 2'b01 && presp) phy_mem[{ppa, pra}] = pwd;
      end
      pk++;
    end
  end

  always @(negedge mdc) begin
    phy_drv = 1'b0; phy_val = 1'b1;
    if (pin && pop == 2'b10 && presp) begin
      if (pk == 13) begin phy_drv = 1'b1; phy_val = 1'b0; end
      else if (pk >= 14 && pk <= 29) begin
        phy_drv = 1'b1; phy_val = phy_mem[{ppa, pra}][29 - pk];
      end
    end
  end

  // bus monitor
  bit prev_oe = 1'b0, prev_mdc = 1'b0;
  int fcnt = 100, per_cnt = 0, last_period = 0, frames_seen = 0;
  logic [63:0] hist = '0, oeh = '0, last_frame = '0, last_oe = '0;
  bit poll_watch = 1'b0, poll_have = 1'b0;
  logic [4:0] poll_prev = '0;
  int poll_err = 0, poll_cnt = 0;

  always @(negedge clk) begin
    per_cnt++;
    if (mdio_oe && !prev_oe) fcnt = 0;
    if (mdc && !prev_mdc) begin
      last_period = per_cnt; per_cnt = 0;
      hist = {hist[62:0], mdio_bus};
      oeh  = {oeh[62:0], mdio_oe};
      fcnt++;
      if (fcnt == 64) begin
        last_frame = hist; last_oe = oeh; frames_seen++;
        if (poll_watch && hist[29:28] == 2'b10 && hist[22:18] == 5'd1) begin
          if (poll_have && hist[27:23] != poll_prev + 5'd1) poll_err++;
          poll_prev = hist[27:23]; poll_have = 1'b1; poll_cnt++;
        end
      end
    end
    prev_oe = mdio_oe; prev_mdc = mdc;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  logic [63:0] snap_frame, snap_oe;
  int snap_period;

  task automatic wait_go_clear();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd_reg(2'd1, v);
      if (!v[31]) begin
        snap_frame = last_frame; snap_oe = last_oe; snap_period = last_period;
        return;
      end
    end
  endtask

  function automatic logic [31:0] exp_ua(bit rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd);
    logic ack; logic [15:0] d;
    if (rd) begin ack = phy_present[pa]; d = ack ? exp_mem[{pa, ra}] : 16'hFFFF; end
    else begin ack = 1'b0; d = wd; end
    return {1'b0, !rd, ack, 3'b000, ra, pa, d};
  endfunction

  function automatic logic [63:0] exp_frame(bit rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd);
    logic ack; logic [15:0] d;
    ack = phy_present[pa];
    d = rd ? (ack ? exp_mem[{pa, ra}] : 16'hFFFF) : wd;
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra,
            rd ? (ack ? 2'b10 : 2'b11) : 2'b10, d};
  endfunction

  task automatic finish_cmd(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] wd, input int period);
    logic [31:0] v, e, a;
    logic [63:0] ef, eo;
    e  = exp_ua(rd, pa, ra, wd);
    ef = exp_frame(rd, pa, ra, wd);
    eo = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    wait_go_clear();
    rd_reg(2'd1, v);
    if (rd) chk(v == e, "R6 read result", {32'h0, v}, {32'h0, e});
    else    chk(v == e, "R3 write completion", {32'h0, v}, {32'h0, e});
    if (rd) chk(snap_frame == ef && snap_oe == eo, "R4 read frame", snap_frame, ef);
    else    chk(snap_frame == ef && snap_oe == eo, "R5 write frame", snap_frame, ef);
    if (period > 0) chk(snap_period == period, "R7 mdc period", 64'(snap_period), 64'(period));
    if (rd) begin
      rd_reg(2'd2, a);
      chk(a[pa] == phy_present[pa], "R9 presence bit", {63'h0, a[pa]}, {63'h0, phy_present[pa]});
    end
    if (!rd && phy_present[pa]) exp_mem[{pa, ra}] = wd;
  endtask

  task automatic do_cmd(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, input int period);
    wr_reg(2'd1, {1'b1, !rd, 1'b0, 3'b000, ra, pa, wd});
    finish_cmd(rd, pa, ra, wd, period);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int fs0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin
      phy_mem[i] = 16'(i * 40503) ^ 16'h5A5A;
      exp_mem[i] = phy_mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd_reg(2'd0, v); chk(v == 32'h8000_0000, "R1 control reset", {32'h0, v}, 64'h8000_0000);
    rd_reg(2'd1, v); chk(v == 32'h0, "R1 command reset", {32'h0, v}, 64'h0);
    rd_reg(2'd2, v); chk(v == 32'h0, "R1 presence reset", {32'h0, v}, 64'h0);
    chk(!mdc && !mdio_oe, "R1 pins reset", {62'h0, mdc, mdio_oe}, 64'h0);

    // disabled: GO stays pending
    wr_reg(2'd0, 32'd3);
    wr_reg(2'd1, {1'b1, 1'b0, 1'b0, 3'b000, 5'd2, 5'd1, 16'h0});
    repeat (400) @(negedge clk);
    rd_reg(2'd1, v); chk(v[31] == 1'b1, "R11 GO pending while disabled", {63'h0, v[31]}, 64'h1);
    chk(frames_seen == 0 && !mdc, "R11 no frame while disabled", 64'(frames_seen), 64'h0);
    rd_reg(2'd0, v); chk(v[31] == 1'b1, "R12 idle while disabled", {63'h0, v[31]}, 64'h1);

    wr_reg(2'd0, 32'h4000_0003);
    repeat (2) @(negedge clk);
    rd_reg(2'd0, v); chk(v[31] == 1'b0, "R12 busy during frame", {63'h0, v[31]}, 64'h0);
    finish_cmd(1'b1, 5'd1, 5'd2, 16'h0, 4);

    // R8: second command while GO set is dropped
    wr_reg(2'd1, {1'b1, 1'b0, 1'b0, 3'b000, 5'd3, 5'd4, 16'h0});
    wr_reg(2'd1, {1'b1, 1'b1, 1'b0, 3'b000, 5'd9, 5'd8, 16'h1234});
    finish_cmd(1'b1, 5'd4, 5'd3, 16'h0, 4);
    do_cmd(1'b1, 5'd8, 5'd9, 16'h0, 4);
    chk(phy_mem[{5'd8, 5'd9}] == exp_mem[{5'd8, 5'd9}], "R8 ignored write left PHY untouched",
        {48'h0, phy_mem[{5'd8, 5'd9}]}, {48'h0, exp_mem[{5'd8, 5'd9}]});

    // divider 0 acts as 1
    wr_reg(2'd0, 32'h4000_0000);
    do_cmd(1'b1, 5'd0, 5'd5, 16'h0, 2);

    // R2: fields stored without GO
    wr_reg(2'd1, {1'b0, 1'b1, 1'b0, 3'b000, 5'h15, 5'h0A, 16'hBEEF});
    repeat (300) @(negedge clk);
    rd_reg(2'd1, v);
    chk(v == {1'b0, 1'b1, 1'b0, 3'b000, 5'h15, 5'h0A, 16'hBEEF}, "R2 field layout",
        {32'h0, v}, {32'h0, 1'b0, 1'b1, 1'b0, 3'b000, 5'h15, 5'h0A, 16'hBEEF});
    chk(phy_mem[{5'h0A, 5'h15}] == exp_mem[{5'h0A, 5'h15}], "R2 no frame without GO",
        {48'h0, phy_mem[{5'h0A, 5'h15}]}, {48'h0, exp_mem[{5'h0A, 5'h15}]});

    // write then read back through a present PHY
    do_cmd(1'b0, 5'd31, 5'd7, 16'hC0DE, 2);
    do_cmd(1'b1, 5'd31, 5'd7, 16'h0, 2);

    // constrained random
    for (int n = 0; n < 24; n++) begin
      int d, per;
      logic [4:0] pa, ra;
      logic [15:0] wd;
      bit rd;
      d = $urandom % 5;
      per = (d == 0 ? 1 : d) + 1;
      wr_reg(2'd0, 32'h4000_0000 | 32'(d));
      case ($urandom % 6)
        0: pa = 5'd0; 1: pa = 5'd1; 2: pa = 5'd4; 3: pa = 5'd8; 4: pa = 5'd31;
        default: pa = 5'($urandom);
      endcase
      ra = 5'($urandom);
      wd = 16'($urandom);
      rd = ($urandom % 2) == 0;
      do_cmd(rd, pa, ra, wd, per);
    end

    // presence follows the latest answer
    wr_reg(2'd0, 32'h4000_0001);
    phy_present[4] = 1'b0;
    do_cmd(1'b1, 5'd4, 5'd1, 16'h0, 2);
    phy_present[4] = 1'b1;
    do_cmd(1'b1, 5'd4, 5'd1, 16'h0, 2);

    // background scan
    poll_watch = 1'b1;
    fs0 = frames_seen;
    for (int i = 0; i < 20000 && frames_seen < fs0 + 40; i++) @(negedge clk);
    poll_watch = 1'b0;
    chk(poll_err == 0 && poll_cnt >= 32, "R10 scan order", 64'(poll_err), 64'h0);
    rd_reg(2'd2, v);
    chk(v == phy_present, "R9 presence map after scan", {32'h0, v}, {32'h0, phy_present});

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule